// File: doc/BRIEF.md
# Peripheral handshake DMA channel

This block is one DMA channel that moves data between memory and an external peripheral. The peripheral is paced by three signals: a request input, an acknowledge output, and one end-of-block line. The end-of-block line either drives a terminal-count strobe out or receives an end-of-transfer signal in. Each individual transfer is a single byte-wide or word-wide access on a simple bus-master port that uses request, grant, address, size, direction and data. The data phase happens in the grant cycle. After each granted access the acknowledge output stays active for a programmable number of wait states. The next bus request is held off until the request line is seen active again after that window closes.

The channel holds two buffer descriptors, each with a start address and a byte count. A block ends when the count runs out or when the peripheral signals the end, whichever happens first. At that point the channel latches two status flags that say which condition ended the block, and it raises a sticky interrupt. If rollover is enabled and the other descriptor is loaded, the channel continues with that descriptor. Otherwise it stops and reports idle until software loads a descriptor again.

Top module: `hsdma_chan`

## Requirements
- R1: After reset: `bus_req` is 0, `dack_o` sits at its inactive level (equal to `cfg_ack_low`), `irq` is 0, `stat_idle` is 1, and `eot_oe` equals `cfg_eot_out`.
- R2: In level mode (`cfg_req_edge`=0) the request counts as active when `dreq_i` differs from `cfg_req_low`. No bus request is issued while it is inactive. While it is held active, transfers follow one another back to back.
- R3: In edge mode (`cfg_req_edge`=1) each inactive-to-active transition of the request allows exactly one transfer. A request held active after one edge yields only that one transfer.
- R4: `dack_o` is active (level `~cfg_ack_low`) starting in the cycle after a grant. It stays active for exactly `cfg_waits`+1 cycles per transfer.
- R5: `bus_req` is never asserted while the acknowledge is active, nor in the first cycle after it ends.
- R6: With `cfg_word`=0 each access is a byte (`bus_word`=0) and the address advances by 1. With `cfg_word`=1 each access is a word (`bus_word`=1) and the address advances by 4. The count falls by the same step and saturates at 0, so a block takes ceil(count/step) transfers.
- R7: When `cfg_eot_out`=1 the end line is an output. The terminal-count level `~cfg_eot_low` appears only while the acknowledge is active, and only on the transfer that exhausts the count.
- R8: When `cfg_eot_out`=0 the end line is an input, active when `eot_i` differs from `cfg_eot_low`. If it is active when a request is accepted (level mode) or at the request's edge (edge mode), that transfer is the last one. It sets `stat_eot_hit`, and `stat_count_hit` is set only if the count also ran out.
- R9: Block completion sets `irq` in the cycle the final acknowledge ends. `irq` stays set until `irq_clr` is pulsed.
- R10: With `cfg_rollover`=1 the channel switches to the other descriptor when it is loaded and continues there. Otherwise it stays on the same descriptor, which is now spent, and `stat_idle` goes to 1. Loading a descriptor with a count of 0 leaves it unloaded.
- R11: On a memory write (`cfg_mem_wr`=1) `bus_wdata` carries `pdat_i`. On a memory read, `pdat_o` holds the `bus_rdata` value from the grant cycle, starting in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_word | input | 1 | 1: word-wide peripheral, 0: byte-wide |
| cfg_mem_wr | input | 1 | 1: peripheral to memory (bus write), 0: memory to peripheral (bus read) |
| cfg_req_edge | input | 1 | Request sensing: 1 edge, 0 level |
| cfg_req_low | input | 1 | Request active low |
| cfg_ack_low | input | 1 | Acknowledge active low |
| cfg_eot_out | input | 1 | End line direction: 1 drives terminal count, 0 accepts end-of-transfer |
| cfg_eot_low | input | 1 | End line active low |
| cfg_rollover | input | 1 | Switch to the other descriptor on completion |
| cfg_waits | input | WSW | Wait states the acknowledge is held after each access |
| desc_load | input | 1 | Load strobe for a descriptor |
| desc_sel | input | 1 | Descriptor to load |
| desc_addr | input | AW | Start address to load |
| desc_bytes | input | CW | Byte count to load |
| irq_clr | input | 1 | Clears the interrupt |
| dreq_i | input | 1 | Peripheral request |
| dack_o | output | 1 | Peripheral acknowledge |
| eot_i | input | 1 | End line, input value |
| eot_o | output | 1 | End line, driven value |
| eot_oe | output | 1 | End line output enable |
| bus_req | output | 1 | Bus access request |
| bus_gnt | input | 1 | Bus grant; data phase in this cycle |
| bus_addr | output | AW | Access address |
| bus_word | output | 1 | Access size: 1 word, 0 byte |
| bus_write | output | 1 | Access direction: 1 write |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| pdat_i | input | DW | Data from the peripheral |
| pdat_o | output | DW | Data to the peripheral |
| irq | output | 1 | Completion interrupt, sticky |
| stat_count_hit | output | 1 | Last block ended with the count exhausted |
| stat_eot_hit | output | 1 | Last block ended by the peripheral |
| stat_idle | output | 1 | Current descriptor not loaded |
| desc_cur | output | 1 | Index of the current descriptor |

## Verification
The request line is driven in four ways: held active for a whole block, pulsed once per transfer in level mode, pulsed in edge mode, and held in edge mode. Together these separate level sensing from edge sensing and show that a held edge gives only one transfer. The end-of-block condition is reached by count expiry alone, by a peripheral end alone, and by both in the same transfer, so the two status flags are checked independently. Randomized blocks vary width, wait states, polarities, count and grant delay. They are checked against transfer counts and address sequences computed from the step rule, which catches errors in the step, the saturation and the acknowledge length.

// File: rtl/hsdma_pkg.sv
package hsdma_pkg;

  typedef enum logic [1:0] {
    HS_WAIT = 2'd0,
    HS_REQ  = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;

  // bytes moved by one access
  function automatic logic [2:0] xfer_bytes(input logic word);
    return word ? 3'd4 : 3'd1;
  endfunction

  // remaining count after one access, saturating at zero
  function automatic logic [31:0] bytes_left(input logic [31:0] cnt, input logic word);
    logic [31:0] s;
    s = {29'd0, xfer_bytes(word)};
    return (cnt > s) ? (cnt - s) : 32'd0;
  endfunction

  function automatic logic [31:0] addr_next(input logic [31:0] a, input logic word);
    return a + {29'd0, xfer_bytes(word)};
  endfunction

endpackage

// File: rtl/hsdma_req_sense.sv
module hsdma_req_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq_i,
  input  logic eot_i,
  input  logic req_low,
  input  logic eot_low,
  input  logic edge_mode,
  input  logic eot_in_en,
  input  logic take_i,
  output logic req_ok_o,
  output logic eot_ok_o
);
  logic act, act_q, rise, eot_act;
  logic pend_q, pend_eot_q;

  assign act     = dreq_i ^ req_low;
  assign eot_act = eot_in_en & (eot_i ^ eot_low);
  assign rise    = act & ~act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_eot_q <= 1'b0;
    end else begin
      act_q  <= act;
      pend_q <= rise | (pend_q & ~take_i);
      if (rise)        pend_eot_q <= eot_act;
      else if (take_i) pend_eot_q <= 1'b0;
    end
  end

  assign req_ok_o = edge_mode ? pend_q     : act;
  assign eot_ok_o = edge_mode ? pend_eot_q : eot_act;

  // R3
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && take_i && !rise) |=> !pend_q);

endmodule

// File: rtl/hsdma_pacer.sv
module hsdma_pacer #(
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [WSW-1:0] waits_i,
  output logic           busy_o,
  output logic           tail_o
);
  logic [WSW-1:0] left_q;
  logic           busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      left_q <= waits_i;
    end else if (busy_q) begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign tail_o = busy_q && (left_q == '0);

  // R4
  dack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && left_q != '0) |=> busy_q);
  // R4
  dack_spont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> !busy_q);

endmodule

// File: rtl/hsdma_desc.sv
module hsdma_desc
  import hsdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic          ld_idx_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [CW-1:0] ld_cnt_i,
  input  logic          step_i,
  input  logic          word_i,
  input  logic          finish_i,
  input  logic          roll_i,
  output logic          cur_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [CW-1:0] cur_cnt_o,
  output logic          cur_valid_o,
  output logic          final_o
);
  localparam int NDESC = 2;

  logic                     cur_q;
  logic [NDESC-1:0][AW-1:0] addr_w;
  logic [NDESC-1:0][CW-1:0] cnt_w;
  logic [NDESC-1:0]         vld_w;

  for (genvar d = 0; d < NDESC; d++) begin : g_slot
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          vld_q;
    logic          hit_ld, hit_cur;

    assign hit_ld  = ld_i && (ld_idx_i == 1'(d));
    assign hit_cur = (cur_q == 1'(d));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q <= '0;
        cnt_q  <= '0;
        vld_q  <= 1'b0;
      end else if (hit_ld) begin
        addr_q <= ld_addr_i;
        cnt_q  <= ld_cnt_i;
        vld_q  <= (ld_cnt_i != '0);
      end else begin
        if (step_i && hit_cur) begin
          addr_q <= AW'(addr_next(32'(addr_q), word_i));
          cnt_q  <= CW'(bytes_left(32'(cnt_q), word_i));
        end
        if (finish_i && hit_cur) vld_q <= 1'b0;
      end
    end

    assign addr_w[d] = addr_q;
    assign cnt_w[d]  = cnt_q;
    assign vld_w[d]  = vld_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  cur_q <= 1'b0;
    else if (finish_i && roll_i && vld_w[~cur_q]) cur_q <= ~cur_q;
  end

  assign cur_o       = cur_q;
  assign cur_addr_o  = addr_w[cur_q];
  assign cur_cnt_o   = cnt_w[cur_q];
  assign cur_valid_o = vld_w[cur_q];
  assign final_o     = (bytes_left(32'(cnt_w[cur_q]), word_i) == 32'd0);

  // R6
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !finish_i) |=> (cur_cnt_o <= $past(cur_cnt_o)));
  // R10
  stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_i && !roll_i) |=> (cur_o == $past(cur_o)));

endmodule

// File: rtl/hsdma_chan.sv
module hsdma_chan
  import hsdma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_enable,
  input  logic           cfg_word,
  input  logic           cfg_mem_wr,
  input  logic           cfg_req_edge,
  input  logic           cfg_req_low,
  input  logic           cfg_ack_low,
  input  logic           cfg_eot_out,
  input  logic           cfg_eot_low,
  input  logic           cfg_rollover,
  input  logic [WSW-1:0] cfg_waits,
  input  logic           desc_load,
  input  logic           desc_sel,
  input  logic [AW-1:0]  desc_addr,
  input  logic [CW-1:0]  desc_bytes,
  input  logic           irq_clr,
  input  logic           dreq_i,
  output logic           dack_o,
  input  logic           eot_i,
  output logic           eot_o,
  output logic           eot_oe,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_word,
  output logic           bus_write,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic [DW-1:0]  pdat_i,
  output logic [DW-1:0]  pdat_o,
  output logic           irq,
  output logic           stat_count_hit,
  output logic           stat_eot_hit,
  output logic           stat_idle,
  output logic           desc_cur
);
  hs_state_e     state_q;
  logic          req_ok, eot_ok, go, grant_evt, finish_evt;
  logic          ack_busy, ack_tail, tc_act;
  logic          cur_valid, final_cnt;
  logic          eot_hit_q, cnt_end_q;
  logic          irq_q, stat_cnt_q, stat_eot_q;
  logic [CW-1:0] cur_cnt;
  logic [DW-1:0] pdat_q;

  hsdma_req_sense u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .dreq_i    (dreq_i),
    .eot_i     (eot_i),
    .req_low   (cfg_req_low),
    .eot_low   (cfg_eot_low),
    .edge_mode (cfg_req_edge),
    .eot_in_en (~cfg_eot_out),
    .take_i    (grant_evt),
    .req_ok_o  (req_ok),
    .eot_ok_o  (eot_ok)
  );

  hsdma_pacer #(.WSW(WSW)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (grant_evt),
    .waits_i (cfg_waits),
    .busy_o  (ack_busy),
    .tail_o  (ack_tail)
  );

  hsdma_desc #(.AW(AW), .CW(CW)) u_desc (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_i        (desc_load),
    .ld_idx_i    (desc_sel),
    .ld_addr_i   (desc_addr),
    .ld_cnt_i    (desc_bytes),
    .step_i      (grant_evt),
    .word_i      (cfg_word),
    .finish_i    (finish_evt),
    .roll_i      (cfg_rollover),
    .cur_o       (desc_cur),
    .cur_addr_o  (bus_addr),
    .cur_cnt_o   (cur_cnt),
    .cur_valid_o (cur_valid),
    .final_o     (final_cnt)
  );

  assign go         = (state_q == HS_WAIT) && cfg_enable && cur_valid && req_ok;
  assign grant_evt  = (state_q == HS_REQ) && bus_gnt;
  assign finish_evt = (state_q == HS_ACK) && ack_tail && (cnt_end_q || eot_hit_q);
  assign tc_act     = ack_busy && cnt_end_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= HS_WAIT;
      eot_hit_q <= 1'b0;
      cnt_end_q <= 1'b0;
    end else begin
      case (state_q)
        HS_WAIT: if (go) begin
          state_q   <= HS_REQ;
          eot_hit_q <= eot_ok;
        end
        HS_REQ: if (bus_gnt) begin
          state_q   <= HS_ACK;
          cnt_end_q <= final_cnt;
        end
        HS_ACK: if (ack_tail) state_q <= HS_WAIT;
        default: state_q <= HS_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q      <= 1'b0;
      stat_cnt_q <= 1'b0;
      stat_eot_q <= 1'b0;
      pdat_q     <= '0;
    end else begin
      if (finish_evt) begin
        irq_q      <= 1'b1;
        stat_cnt_q <= cnt_end_q;
        stat_eot_q <= eot_hit_q;
      end else if (irq_clr) begin
        irq_q <= 1'b0;
      end
      if (grant_evt && !cfg_mem_wr) pdat_q <= bus_rdata;
    end
  end

  assign bus_req        = (state_q == HS_REQ);
  assign bus_word       = cfg_word;
  assign bus_write      = cfg_mem_wr;
  assign bus_wdata      = pdat_i;
  assign pdat_o         = pdat_q;
  assign dack_o         = ack_busy ^ cfg_ack_low;
  assign eot_oe         = cfg_eot_out;
  assign eot_o          = (cfg_eot_out & tc_act) ^ cfg_eot_low;
  assign irq            = irq_q;
  assign stat_count_hit = stat_cnt_q;
  assign stat_eot_hit   = stat_eot_q;
  assign stat_idle      = ~cur_valid;

  // R5
  no_req_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_busy |-> !bus_req);
  // R4
  ack_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_busy) |-> $past(bus_req && bus_gnt));
  // R4
  ack_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_ACK) == ack_busy);
  // R7
  tc_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_act |-> ack_busy);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr)));

endmodule

// File: tb/hsdma_chan_bench.sv
module hsdma_chan_bench;
  localparam int AW = 32, DW = 32, CW = 16, WSW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cfg_enable = 1, cfg_word = 0, cfg_mem_wr = 0, cfg_req_edge = 0, cfg_req_low = 0;
  logic cfg_ack_low = 0, cfg_eot_out = 1, cfg_eot_low = 0, cfg_rollover = 0;
  logic [WSW-1:0] cfg_waits = 2;
  logic desc_load = 0, desc_sel = 0, irq_clr = 0, dreq_i = 0, eot_i = 0, bus_gnt = 0;
  logic [AW-1:0] desc_addr = 0;
  logic [CW-1:0] desc_bytes = 0;
  logic [DW-1:0] pdat_i = 0, bus_rdata, pdat_o, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic dack_o, eot_o, eot_oe, bus_req, bus_word, bus_write, irq;
  logic stat_count_hit, stat_eot_hit, stat_idle, desc_cur;

  assign bus_rdata = {bus_addr[15:0], ~bus_addr[15:0]};

  hsdma_chan #(.AW(AW), .DW(DW), .CW(CW), .WSW(WSW)) u_hsdma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_word(cfg_word),
    .cfg_mem_wr(cfg_mem_wr), .cfg_req_edge(cfg_req_edge), .cfg_req_low(cfg_req_low),
    .cfg_ack_low(cfg_ack_low), .cfg_eot_out(cfg_eot_out), .cfg_eot_low(cfg_eot_low),
    .cfg_rollover(cfg_rollover), .cfg_waits(cfg_waits), .desc_load(desc_load),
    .desc_sel(desc_sel), .desc_addr(desc_addr), .desc_bytes(desc_bytes),
    .irq_clr(irq_clr), .dreq_i(dreq_i), .dack_o(dack_o), .eot_i(eot_i),
    .eot_o(eot_o), .eot_oe(eot_oe), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .bus_word(bus_word), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pdat_i(pdat_i), .pdat_o(pdat_o),
    .irq(irq), .stat_count_hit(stat_count_hit), .stat_eot_hit(stat_eot_hit),
    .stat_idle(stat_idle), .desc_cur(desc_cur)
  );

  int total = 0, bad = 0;
  int ngrant = 0, n_ack_end = 0, run = 0, tc_cnt = 0, tc_at = 0;
  logic prev_dack = 0, prev_gnt = 0, prev_tc = 0, rd_pend = 0, dack_act, tc_act, g;
  logic [DW-1:0] rd_exp = 0;
  logic [AW-1:0] log_addr [256];
  logic          log_word [256];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_xfers(input int cnt, input logic word);
    return word ? (cnt + 3) / 4 : cnt;
  endfunction

  // bus model and protocol monitor
  always @(negedge clk) begin
    dack_act = dack_o ^ cfg_ack_low;
    tc_act   = eot_oe && (eot_o ^ cfg_eot_low);
    if (!rst_n) begin
      bus_gnt = 0; prev_dack = 0; prev_gnt = 0; prev_tc = 0; rd_pend = 0; run = 0;
    end else begin
      if (bus_req && prev_dack) chk(0, "R5 req during ack", 1, 0);
      if (rd_pend) begin chk(pdat_o == rd_exp, "R11 read data", pdat_o, rd_exp); rd_pend = 0; end
      if (prev_gnt) chk(dack_act, "R4 ack after grant", dack_act, 1);
      if (dack_act) run++;
      else if (prev_dack) begin
        chk(run == int'(cfg_waits) + 1, "R4 ack width", run, int'(cfg_waits) + 1);
        run = 0; n_ack_end++;
      end
      if (tc_act && !dack_act) chk(0, "R7 tc outside ack", 1, 0);
      if (tc_act && !prev_tc) begin tc_cnt++; tc_at = ngrant; end
      g = bus_req && ($urandom % 3 != 0);
      if (g) begin
        log_addr[ngrant % 256] = bus_addr;
        log_word[ngrant % 256] = bus_word;
        if (bus_write) chk(bus_wdata == pdat_i, "R11 write data", bus_wdata, pdat_i);
        else begin rd_pend = 1; rd_exp = bus_rdata; end
        ngrant++;
      end else pdat_i = $urandom;
      bus_gnt = g; prev_gnt = g; prev_dack = dack_act; prev_tc = tc_act;
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic wait_acks(input int n);
    int lim = 0;
    while (n_ack_end < n && lim < 3000) begin tick(); lim++; end
    if (lim >= 3000) chk(0, "R4 ack timeout", n_ack_end, n);
  endtask

  task automatic setup(input logic w, input int ws, input logic edg, input logic rl,
                       input logic al, input logic eo, input logic el, input logic ro,
                       input logic mw);
    cfg_word = w; cfg_waits = WSW'(ws); cfg_req_edge = edg; cfg_req_low = rl;
    cfg_ack_low = al; cfg_eot_out = eo; cfg_eot_low = el; cfg_rollover = ro;
    cfg_mem_wr = mw; dreq_i = rl; eot_i = el;
    irq_clr = 1; tick(); irq_clr = 0; tick();
  endtask

  task automatic load(input logic idx, input logic [AW-1:0] a, input int c);
    desc_load = 1; desc_sel = idx; desc_addr = a; desc_bytes = CW'(c);
    tick(); desc_load = 0; tick();
  endtask

  task automatic run_held(input int n, input string req);
    int g0 = ngrant;
    dreq_i = ~cfg_req_low;
    wait_acks(n_ack_end + n);
    dreq_i = cfg_req_low;
    repeat (10) tick();
    chk(ngrant - g0 == n, req, ngrant - g0, n);
  endtask

  // one paced transfer; e marks it as peripheral-ended
  task automatic xfer(input logic e);
    int g0 = ngrant, a0 = n_ack_end, lim = 0;
    dreq_i = ~cfg_req_low;
    if (e && !cfg_eot_out) eot_i = ~cfg_eot_low;
    if (cfg_req_edge) begin
      tick(); dreq_i = cfg_req_low; eot_i = cfg_eot_low;
    end
    while (ngrant == g0 && lim < 500) begin tick(); lim++; end
    dreq_i = cfg_req_low; eot_i = cfg_eot_low;
    chk(ngrant == g0 + 1, "R3 one grant per request", ngrant - g0, 1);
    wait_acks(a0 + 1);
  endtask

  task automatic chk_addrs(input int g0, input logic [AW-1:0] base, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      chk(log_addr[(g0 + k) % 256] == base + AW'(k * (cfg_word ? 4 : 1)), req,
          log_addr[(g0 + k) % 256], base + AW'(k * (cfg_word ? 4 : 1)));
      chk(log_word[(g0 + k) % 256] == cfg_word, req, log_word[(g0 + k) % 256], cfg_word);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) tick();
    // R1 reset state
    rst_n = 1; tick();
    chk(bus_req == 0, "R1 bus_req", bus_req, 0);
    chk(dack_o == cfg_ack_low, "R1 dack idle", dack_o, cfg_ack_low);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(stat_idle == 1, "R1 idle", stat_idle, 1);
    chk(eot_oe == cfg_eot_out, "R1 eot_oe", eot_oe, cfg_eot_out);

    begin : t_count_byte  // R6 R7 byte block, TC out
      int g0, t0;
      setup(0, 2, 0, 0, 0, 1, 0, 0, 0);
      load(0, 32'h100, 5);
      g0 = ngrant; t0 = tc_cnt;
      run_held(5, "R6 byte transfers");
      chk_addrs(g0, 32'h100, 5, "R6 byte address");
      chk(tc_cnt - t0 == 1, "R7 tc count", tc_cnt - t0, 1);
      chk(tc_at == g0 + 5, "R7 tc on final", tc_at, g0 + 5);
      chk(stat_count_hit == 1, "R7 count status", stat_count_hit, 1);
      chk(stat_eot_hit == 0, "R8 no eot status", stat_eot_hit, 0);
      chk(stat_idle == 1, "R10 idle after block", stat_idle, 1);
      // R9 irq sticky
      chk(irq == 1, "R9 irq set", irq, 1);
      repeat (20) tick();
      chk(irq == 1, "R9 irq held", irq, 1);
      irq_clr = 1; tick(); irq_clr = 0; tick();
      chk(irq == 0, "R9 irq cleared", irq, 0);
    end

    begin : t_word_low  // R2 R6 inverted polarities, word size
      int g0;
      setup(1, 1, 0, 1, 1, 1, 1, 0, 1);
      load(0, 32'h400, 10);
      g0 = ngrant;
      repeat (20) tick();
      chk(ngrant == g0, "R2 inactive request", ngrant - g0, 0);
      chk(dack_o == 1, "R4 dack idle low-active", dack_o, 1);
      run_held(3, "R6 word transfers");
      chk_addrs(g0, 32'h400, 3, "R6 word address");
      chk(stat_count_hit == 1, "R6 saturated count", stat_count_hit, 1);
    end

    begin : t_edge  // R3 R8 edge mode with end input
      int g0;
      setup(0, 0, 1, 0, 0, 0, 1, 0, 0);
      chk(eot_oe == 0, "R8 end line input", eot_oe, 0);
      load(0, 32'h20, 8);
      for (int k = 0; k < 3; k++) xfer(0);
      g0 = ngrant;
      dreq_i = 1; repeat (40) tick(); dreq_i = 0; repeat (5) tick();
      chk(ngrant - g0 == 1, "R3 held edge", ngrant - g0, 1);
      chk(irq == 0, "R8 no early end", irq, 0);
      xfer(1);
      chk(irq == 1, "R8 peripheral end irq", irq, 1);
      chk(stat_eot_hit == 1, "R8 eot status", stat_eot_hit, 1);
      chk(stat_count_hit == 0, "R8 count not reached", stat_count_hit, 0);
    end

    begin : t_level_eot  // R8 level mode, then end and count together
      setup(1, 3, 0, 0, 0, 0, 0, 0, 0);
      load(0, 32'h800, 20);
      xfer(0); xfer(0); xfer(1);
      chk(stat_eot_hit == 1, "R8 level eot", stat_eot_hit, 1);
      chk(stat_count_hit == 0, "R8 level count", stat_count_hit, 0);
      setup(0, 0, 0, 0, 0, 0, 0, 0, 1);
      load(0, 32'h40, 2);
      xfer(0); xfer(1);
      chk(stat_eot_hit == 1, "R8 both eot", stat_eot_hit, 1);
      chk(stat_count_hit == 1, "R8 both count", stat_count_hit, 1);
    end

    begin : t_roll  // R10 rollover and stop
      int g0;
      logic c0;
      setup(0, 1, 0, 0, 0, 1, 0, 1, 0);
      c0 = desc_cur;
      load(c0, 32'h200, 3);
      load(~c0, 32'h300, 2);
      load(c0, 32'h200, 0);
      chk(stat_idle == 1, "R10 zero count unloaded", stat_idle, 1);
      load(c0, 32'h200, 3);
      g0 = ngrant;
      run_held(5, "R10 rollover transfers");
      chk_addrs(g0, 32'h200, 3, "R10 first descriptor");
      chk_addrs(g0 + 3, 32'h300, 2, "R10 second descriptor");
      chk(desc_cur == ~c0, "R10 switched", desc_cur, ~c0);
      chk(stat_idle == 1, "R10 stop at end", stat_idle, 1);
      setup(0, 0, 0, 0, 0, 1, 0, 0, 0);
      c0 = desc_cur;
      load(0, 32'h500, 2); load(1, 32'h600, 2);
      run_held(2, "R10 no rollover");
      chk(desc_cur == c0, "R10 stays", desc_cur, c0);
      chk(stat_idle == 1, "R10 idle without rollover", stat_idle, 1);
    end

    for (int it = 0; it < 8; it++) begin : t_rand  // R2 R4 R6 R7 random blocks
      int c, g0, t0, n;
      logic w;
      logic [AW-1:0] base;
      w = 1'($urandom); c = 1 + int'($urandom % 12);
      base = AW'($urandom % 4096) << 2;
      setup(w, int'($urandom % 4), 0, 1'($urandom), 1'($urandom), 1, 1'($urandom), 0,
            1'($urandom));
      load(desc_cur, base, c);
      n = exp_xfers(c, w);
      g0 = ngrant; t0 = tc_cnt;
      run_held(n, "R6 random transfers");
      chk_addrs(g0, base, n, "R6 random address");
      chk(tc_cnt - t0 == 1 && tc_at == g0 + n, "R7 random tc", tc_at, g0 + n);
      chk(stat_count_hit == 1 && irq == 1, "R9 random completion", irq, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", ngrant, -1);
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

endmodule